// File: doc/BRIEF.md
# Fail-First Vector Loop Controller

This block steps a vector operation through element indices 0, 1, 2 and onward, up to the captured vector length minus one. After each element's result arrives, it checks a per-element condition. In fail-first mode, the first element whose condition fails stops the loop. The block then reports a shortened vector length. That length either counts the failing element or leaves it out.

The condition has two possible sources:
- one bit picked from the element's 4-bit condition field, when the record flag `rc_in` is set;
- a zero/nonzero test on the element's result, when `rc_in` is clear.

In every other mode, the block runs the whole loop, writes every element and leaves the length untouched.

A pulse on `start` while the block is idle captures the length, the mode field and the record flag. The block then presents `elem_idx`. It waits for `elem_valid`, together with the flags for that element, before it moves on. For each element it raises the result and condition write enables combinationally. One cycle after the element that ends the loop, it pulses `done` for a single cycle, with the final length on `vl_out`.

Top module: `vloop_ffirst`

## Requirements
- R1: After reset, `done`, `res_we` and `cr_we` are 0, and `vl_out` and `elem_idx` are 0.
- R2: After `start` (accepted only when idle) with a length of 1 or more, `elem_idx` begins at 0. It rises by one after each cycle with `elem_valid` high that does not end the loop, and holds while `elem_valid` is low.
- R3: Fail-first mode is `mode_in[1:0]` = 2'b01, and `mode_in[2]` is the invert flag. With `rc_in`=1, the tested bit is `elem_cr[mode_in[4:3]]`, with `mode_in[4:3]` read as an unsigned index. An element passes when that bit differs from the invert flag.
- R4: In fail-first mode with `rc_in`=0, an element passes when its result is nonzero (`elem_zero`=0) and the invert flag is 0, or when it is zero and the invert flag is 1.
- R5: At the first failing element, the loop stops. `vl_out` becomes that element's index plus one if `rc_in`=0 and `mode_in[3]`=1 (inclusive); otherwise it becomes the index itself.
- R6: An element's write enables rise only in its `elem_valid` cycle, and only if it lies inside the final length. `res_we` is suppressed when `rc_in`=0 and `mode_in[4]`=1. In fail-first mode, `cr_we` rises when `rc_in`=1 or `mode_in[4]`=1.
- R7: If no element fails, `vl_out` equals the captured length, and `done` follows the element at index length-1.
- R8: A start with length 0 gives `done` in the next cycle, with `vl_out`=0 and no write enable.
- R9: When `mode_in[1:0]` is not 2'b01, every element is written: `res_we`=1, and `cr_we` equals `rc_in`. The length is returned unchanged.
- R10: `done` is high for exactly one cycle, the one after the cycle that ends the loop. No write enable is high while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop (taken when idle) |
| vl_in | input | VLW | Vector length to process |
| mode_in | input | 5 | Mode field: [1:0] kind, [2] invert, [4:3] bit select or {store-CR-only, inclusive} |
| rc_in | input | 1 | Record flag: test a condition bit and store condition fields |
| elem_valid | input | 1 | Result flags for the current element are present |
| elem_zero | input | 1 | Current element's result is zero |
| elem_cr | input | 4 | Current element's condition field |
| elem_idx | output | VLW | Index of the element being processed |
| res_we | output | 1 | Write the result element |
| cr_we | output | 1 | Write the condition element |
| vl_out | output | VLW | Resulting vector length |
| done | output | 1 | One-cycle pulse at the end of a loop |

## Verification
The bench sweeps lengths 0 to 5 against all 32 mode values, both record-flag settings and three flag patterns. This covers the condition-bit test with every select index and both senses, and the zero test in both senses. It also covers the inclusive and exclusive truncation, the store-condition-only variant and the non-fail-first modes. Element flags are computed from the index, so failures land at the first element, at middle elements, at the last element, or nowhere. This separates an off-by-one in the new length from a missed or late stop. Periodic cycles with `elem_valid` low show that the index and the write enables wait for valid data.

// File: rtl/vff_pkg.sv
package vff_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vff_state_e;

  localparam logic [1:0] KIND_FFIRST = 2'b01;

  // Condition outcome for one element.
  function automatic logic ff_pass(input logic rc, input logic inv,
                                   input logic [1:0] sel, input logic [3:0] cr,
                                   input logic zero);
    if (rc) return cr[sel] ^ inv;
    return (~zero) ^ inv;
  endfunction

endpackage

// File: rtl/vff_cond.sv
module vff_cond
  import vff_pkg::*;
(
  input  logic       go,
  input  logic       ffirst,
  input  logic       rc,
  input  logic       inv,
  input  logic [1:0] sel,
  input  logic [3:0] cr,
  input  logic       zero,
  output logic       pass,
  output logic       incl,
  output logic       res_we,
  output logic       cr_we
);

  logic keep;
  logic rc1_only;

  always_comb begin
    if (ffirst) begin
      pass     = ff_pass(rc, inv, sel, cr, zero);
      incl     = ~rc & sel[0];
      rc1_only = ~rc & sel[1];
      keep     = pass | incl;
      res_we   = go & keep & ~rc1_only;
      cr_we    = go & keep & (rc | rc1_only);
    end else begin
      pass     = 1'b1;
      incl     = 1'b0;
      rc1_only = 1'b0;
      keep     = 1'b1;
      res_we   = go;
      cr_we    = go & rc;
    end
  end

endmodule

// File: rtl/vff_seq.sv
module vff_seq
  import vff_pkg::*;
#(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic           valid,
  input  logic           pass,
  input  logic           incl,
  output logic           accept,
  output logic           busy,
  output logic           go,
  output logic [VLW-1:0] idx,
  output logic [VLW-1:0] vl_out,
  output logic           done
);

  vff_state_e     state;
  logic [VLW-1:0] vl_cap;
  logic           fail_evt;
  logic           last_evt;

  assign busy     = (state == ST_RUN);
  assign done     = (state == ST_FIN);
  assign accept   = start & (state == ST_IDLE);
  assign go       = busy & valid;
  assign fail_evt = go & ~pass;
  assign last_evt = go & pass & (idx == vl_cap - VLW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      vl_cap <= '0;
      vl_out <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          vl_cap <= vl_in;
          idx    <= '0;
          if (vl_in == '0) begin
            vl_out <= vl_in;
            state  <= ST_FIN;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (fail_evt) begin
            vl_out <= idx + VLW'(incl);
            state  <= ST_FIN;
          end else if (last_evt) begin
            vl_out <= vl_cap;
            state  <= ST_FIN;
          end else if (go) begin
            idx <= idx + VLW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !valid |=> $stable(idx)); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    go && !fail_evt && !last_evt |=> idx == $past(idx) + VLW'(1)); // R2
  AST_TRUNC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> done && vl_out == $past(idx) + VLW'($past(incl))); // R5
  AST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> done && vl_out == $past(vl_cap)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vl_out <= vl_cap); // R5

endmodule

// File: rtl/vloop_ffirst.sv
module vloop_ffirst
  import vff_pkg::*;
#(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic [4:0]     mode_in,
  input  logic           rc_in,
  input  logic           elem_valid,
  input  logic           elem_zero,
  input  logic [3:0]     elem_cr,
  output logic [VLW-1:0] elem_idx,
  output logic           res_we,
  output logic           cr_we,
  output logic [VLW-1:0] vl_out,
  output logic           done
);

  logic [4:0] mode_q;
  logic       rc_q;
  logic       ffirst_q;
  logic       accept;
  logic       busy;
  logic       go;
  logic       pass;
  logic       incl;

  assign ffirst_q = (mode_q[1:0] == KIND_FFIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rc_q   <= 1'b0;
    end else if (accept) begin
      mode_q <= mode_in;
      rc_q   <= rc_in;
    end
  end

  vff_cond u_cond (
    .go     (go),
    .ffirst (ffirst_q),
    .rc     (rc_q),
    .inv    (mode_q[2]),
    .sel    (mode_q[4:3]),
    .cr     (elem_cr),
    .zero   (elem_zero),
    .pass   (pass),
    .incl   (incl),
    .res_we (res_we),
    .cr_we  (cr_we)
  );

  vff_seq #(.VLW(VLW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .vl_in  (vl_in),
    .valid  (elem_valid),
    .pass   (pass),
    .incl   (incl),
    .accept (accept),
    .busy   (busy),
    .go     (go),
    .idx    (elem_idx),
    .vl_out (vl_out),
    .done   (done)
  );

  AST_WE_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we || cr_we) |-> busy && elem_valid); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !res_we && !cr_we); // R10
  AST_RC1_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ffirst_q && !rc_q && mode_q[4] |-> !res_we); // R6
  AST_PLAIN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    go && !ffirst_q |-> res_we && cr_we == rc_q); // R9

endmodule

// File: tb/vloop_ffirst_test.sv
module vloop_ffirst_test;

  localparam int MAXVL = 64;
  localparam int VLW   = $clog2(MAXVL + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [VLW-1:0] vl_in = '0;
  logic [4:0]     mode_in = '0;
  logic           rc_in = 1'b0;
  logic           elem_valid = 1'b0;
  logic           elem_zero = 1'b0;
  logic [3:0]     elem_cr = '0;
  logic [VLW-1:0] elem_idx;
  logic           res_we;
  logic           cr_we;
  logic [VLW-1:0] vl_out;
  logic           done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vloop_ffirst #(.MAXVL(MAXVL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
    .mode_in(mode_in), .rc_in(rc_in), .elem_valid(elem_valid),
    .elem_zero(elem_zero), .elem_cr(elem_cr), .elem_idx(elem_idx),
    .res_we(res_we), .cr_we(cr_we), .vl_out(vl_out), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int vl, input int m, input int r, input int pat);
    bit ff, inv, vli, rc1, pass, keep, stop, er, ec;
    int sel, e, cyc, newvl;
    string wtag;
    ff  = (m & 3) == 1;
    inv = (m >> 2) & 1;
    sel = (m >> 3) & 3;
    vli = (m >> 3) & 1;
    rc1 = (m >> 4) & 1;
    wtag = !ff ? "R9 write" : (r != 0) ? "R3/R6 write" : "R4/R6 write";
    @(negedge clk);
    start = 1; vl_in = VLW'(vl); mode_in = 5'(m); rc_in = r[0]; elem_valid = 0;
    @(negedge clk);
    start = 0;
    if (vl == 0) begin
      #1;
      chk(done == 1, "R8 done", done, 1);
      chk(vl_out == 0, "R8 vl_out", vl_out, 0);
      chk(!res_we && !cr_we, "R8 writes", res_we + cr_we, 0);
      return;
    end
    e = 0; stop = 0; cyc = 0; newvl = vl;
    while (!stop) begin
      elem_valid = ((cyc + pat) % 4) != 3;
      elem_zero  = ((e * 3 + pat + m) % 5) == 0;
      elem_cr    = 4'((e * 5 + pat * 7 + m + r) & 15);
      #1;
      if (!ff) pass = 1;
      else if (r != 0) pass = elem_cr[sel] != inv;
      else pass = (!elem_zero) != inv;
      keep = pass || (ff && r == 0 && vli);
      er = elem_valid && keep && !(ff && r == 0 && rc1);
      ec = elem_valid && keep && ((r != 0) || (ff && rc1));
      chk(elem_idx == VLW'(e), "R2 index", elem_idx, e);
      chk(res_we == er, {wtag, " res_we"}, res_we, er);
      chk(cr_we == ec, {wtag, " cr_we"}, cr_we, ec);
      chk(done == 0, "R10 early done", done, 0);
      if (elem_valid) begin
        if (!pass) begin
          newvl = e + ((ff && r == 0 && vli) ? 1 : 0);
          stop = 1;
        end else if (e == vl - 1) begin
          stop = 1;
        end else begin
          e++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    elem_valid = 0;
    #1;
    chk(done == 1, "R10 done pulse", done, 1);
    chk(vl_out == VLW'(newvl), (newvl == vl) ? "R7 length" : "R5 length", vl_out, newvl);
    chk(!res_we && !cr_we, "R10 quiet", res_we + cr_we, 0);
    @(negedge clk);
    chk(done == 0, "R10 single cycle", done, 0);
  endtask

  initial begin
    #5;
    chk(done == 0 && res_we == 0 && cr_we == 0, "R1 outputs", done + res_we + cr_we, 0);
    chk(vl_out == 0 && elem_idx == 0, "R1 state", vl_out + elem_idx, 0);
    #30 rst_n = 1;
    for (int vl = 0; vl <= 5; vl++)
      for (int m = 0; m < 32; m++)
        for (int r = 0; r < 2; r++)
          for (int pat = 0; pat < 3; pat++)
            run(vl, m, r, pat);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule